// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This execution unit takes two XLEN-wide source operands (XLEN is 32 or 64) and splits each one into unsigned byte lanes. It takes the absolute difference of each pair of lanes and adds all of them into one scalar result. A second form of the operation also adds the old destination value, so that a running total can be built over many instructions. The unit also decodes the 32-bit instruction word to choose between the two forms. It flags any word that matches neither form.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. Internally there is a two-stage registered pipeline. The first stage builds the byte differences and the adder tree. The second stage folds in the destination operand. Back-pressure works as follows. A result stays on the output, unchanged, until the consumer raises `out_ready`. A stall at the output fills the second stage first and then the first stage. Only after that does `in_ready` drop. Nothing is lost or reordered. When `out_ready` stays high, one operation is accepted every cycle.

Top module: `bsad_unit`

## Requirements
- R1: Each byte lane of `in_rs1` and `in_rs2` is read as an unsigned 8-bit value, and the lane contributes |rs1 byte − rs2 byte| to the sum.
- R2: The plain form gives the sum of the lane differences over all XLEN/8 lanes, zero-extended to XLEN. For XLEN=32 the maximum is 1020, and for XLEN=64 it is 2040.
- R3: The accumulate form gives `in_rd` plus that sum, wrapped modulo 2^XLEN. There is no saturation and no flag.
- R4: Decoding uses three fields: bits [6:0] must be 1111111 and bits [14:12] must be 000. Bits [31:25] then select the form: 1111110 selects plain and 1111111 selects accumulate. All other instruction bits are ignored.
- R5: Any other instruction word produces a result with `out_illegal`=1 and `out_result`=0, whatever the operands are.
- R6: With `out_ready` high and the pipeline empty, an operation accepted on rising edge k appears with `out_valid`=1 after rising edge k+1, and not before it.
- R7: While `out_ready` is held high, `in_ready` stays high, and one operation can be accepted on every cycle.
- R8: While `out_valid`=1 and `out_ready`=0, the output holds its value into the next cycle. Every accepted operation comes out exactly once, in the order it was accepted.
- R9: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_insn | input | 32 | Instruction word to decode |
| in_rs1 | input | XLEN | First source operand |
| in_rs2 | input | XLEN | Second source operand |
| in_rd | input | XLEN | Old destination value (used by accumulate form) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | XLEN | Result value |
| out_illegal | output | 1 | Instruction word matched neither form |

## Verification
A result is due after the second rising edge, counting the edge that accepted the operation. A directed check shows that `out_valid` is still low after the first edge and high after the second. Most other checks do not count cycles. They use an in-order scoreboard of expected values that is filled when an operation is accepted and read when a result is handed over. This keeps them correct under the pseudo-random `out_ready` stalls used in the sweep. During a stall, the value on the output is compared with itself one cycle later. In a run with `out_ready` held high, `in_ready` is sampled once per cycle.

// File: rtl/bsad_pkg.sv
package bsad_pkg;
  localparam logic [6:0] OPC_PACKED = 7'b1111111;
  localparam logic [2:0] F3_SAD     = 3'b000;
  localparam logic [6:0] F7_PLAIN   = 7'b1111110;
  localparam logic [6:0] F7_ACCUM   = 7'b1111111;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_ACCUM = 2'd1,
    OP_BAD   = 2'd2
  } sad_op_e;
endpackage

// File: rtl/bsad_decode.sv
module bsad_decode
  import bsad_pkg::*;
(
  input  logic [31:0] insn,
  output sad_op_e     op
);
  logic unused_fields;
  assign unused_fields = ^{insn[24:15], insn[11:7]};

  always_comb begin
    op = OP_BAD;
    if (insn[6:0] == OPC_PACKED && insn[14:12] == F3_SAD) begin
      if (insn[31:25] == F7_PLAIN)      op = OP_PLAIN;
      else if (insn[31:25] == F7_ACCUM) op = OP_ACCUM;
    end
  end
endmodule

// File: rtl/bsad_absdiff.sv
module bsad_absdiff #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] d
);
  always_comb d = (a >= b) ? (a - b) : (b - a);
endmodule

// File: rtl/bsad_tree.sv
module bsad_tree #(
  parameter int LANES = 8,
  parameter int SUM_W = 11
) (
  input  logic [LANES*8-1:0] diffs,
  output logic [SUM_W-1:0]   sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++)
      sum = sum + {{(SUM_W-8){1'b0}}, diffs[i*8 +: 8]};
  end
endmodule

// File: rtl/bsad_unit.sv
module bsad_unit
  import bsad_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_rd,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  localparam int LANES = XLEN / 8;
  localparam int SUM_W = $clog2(LANES * 255 + 1);

  // stage 0: decode and lane differences (combinational)
  sad_op_e          op0;
  logic [XLEN-1:0]  diffs0;
  logic [SUM_W-1:0] sum0;

  bsad_decode u_dec (.insn(in_insn), .op(op0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsad_absdiff #(.W(8)) u_ad (
      .a(in_rs1[g*8 +: 8]),
      .b(in_rs2[g*8 +: 8]),
      .d(diffs0[g*8 +: 8])
    );
  end

  bsad_tree #(.LANES(LANES), .SUM_W(SUM_W)) u_tree (.diffs(diffs0), .sum(sum0));

  // pipeline control
  logic v1, v2, s1_adv, s2_adv;
  assign s2_adv   = !v2 || out_ready;
  assign s1_adv   = !v1 || s2_adv;
  assign in_ready = s1_adv;

  // stage 1 registers
  sad_op_e          op1;
  logic [SUM_W-1:0] sum1;
  logic [XLEN-1:0]  rd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      op1  <= OP_BAD;
      sum1 <= '0;
      rd1  <= '0;
    end else if (s1_adv) begin
      v1 <= in_valid;
      if (in_valid) begin
        op1  <= op0;
        sum1 <= sum0;
        rd1  <= in_rd;
      end
    end
  end

  // stage 2: fold in destination, register result
  logic [XLEN-1:0] sum1_ext, res1;
  sad_op_e         op2;
  logic [XLEN-1:0] res2;

  assign sum1_ext = {{(XLEN-SUM_W){1'b0}}, sum1};

  always_comb begin
    unique case (op1)
      OP_PLAIN: res1 = sum1_ext;
      OP_ACCUM: res1 = rd1 + sum1_ext;
      default:  res1 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      op2  <= OP_BAD;
      res2 <= '0;
    end else if (s2_adv) begin
      v2 <= v1;
      if (v1) begin
        op2  <= op1;
        res2 <= res1;
      end
    end
  end

  assign out_valid   = v2;
  assign out_result  = res2;
  assign out_illegal = (op2 == OP_BAD);

  // assertions
  p_stage_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> v1);

  p_s1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !s2_adv) |=> (v1 && $stable(sum1) && $stable(rd1)));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  p_plain_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && op2 == OP_PLAIN) |-> ((res2 >> SUM_W) == '0));

  p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));
endmodule

// File: tb/bsad_unit_test.sv
`timescale 1ns/1ps
module bsad_unit_test;
  localparam int XW = 32;
  localparam int LN = XW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_insn = '0;
  logic [XW-1:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [XW-1:0] out_result;
  logic          out_illegal;

  always #4 clk = ~clk;

  bsad_unit #(.XLEN(XW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  int checks = 0, fails = 0;
  logic [XW-1:0] exp_res [0:1023];
  logic          exp_ill [0:1023];
  int wr_ptr = 0, rd_ptr = 0;
  logic bp_en = 1'b0, stream_chk = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic hold_pend = 1'b0;
  logic [XW-1:0] held_res;

  function automatic logic [31:0] mk(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [XW-1:0] ref_sad(logic [XW-1:0] a, logic [XW-1:0] b);
    int s = 0;
    for (int l = 0; l < LN; l++) begin
      int x = int'(a[l*8 +: 8]);
      int y = int'(b[l*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return XW'(s);
  endfunction

  task automatic chk(string req, logic ok, logic [XW-1:0] act, logic [XW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // operation: accepted on the posedge this task returns at
  task automatic send(logic [31:0] insn, logic [XW-1:0] a, logic [XW-1:0] b, logic [XW-1:0] rd);
    logic [XW-1:0] e;
    logic il;
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_rs1 = a; in_rs2 = b; in_rd = rd;
    #1;
    if (stream_chk) chk("R7 in_ready", in_ready == 1'b1, XW'(in_ready), 1);
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    il = 1'b0;
    if (insn[6:0] == 7'b1111111 && insn[14:12] == 3'b000 && insn[31:25] == 7'b1111110)
      e = ref_sad(a, b);
    else if (insn[6:0] == 7'b1111111 && insn[14:12] == 3'b000 && insn[31:25] == 7'b1111111)
      e = rd + ref_sad(a, b);
    else begin
      e = '0; il = 1'b1;
    end
    exp_res[wr_ptr % 1024] = e;
    exp_ill[wr_ptr % 1024] = il;
    wr_ptr++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // output monitor and consumer
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk("R8 hold", out_valid && out_result == held_res, out_result, held_res);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
      hold_pend = out_valid && !out_ready;
      held_res  = out_result;
      if (out_valid && out_ready) begin
        if (rd_ptr >= wr_ptr) chk("R8 extra result", 1'b0, out_result, '0);
        else begin
          chk("R1/R2/R3/R5 result",
              out_result == exp_res[rd_ptr % 1024] && out_illegal == exp_ill[rd_ptr % 1024],
              out_result, exp_res[rd_ptr % 1024]);
          rd_ptr++;
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (rd_ptr < wr_ptr && n < 5000) begin
      @(negedge clk); n++;
    end
    chk("R8 all delivered", rd_ptr == wr_ptr, XW'(rd_ptr), XW'(wr_ptr));
  endtask

  localparam logic [6:0] OPC = 7'b1111111;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 out_valid reset", out_valid == 1'b0, XW'(out_valid), 0);
    chk("R9 in_ready reset", in_ready == 1'b1, XW'(in_ready), 1);

    // R6: latency from accepting edge
    send(mk(7'b1111110, 3'b000, OPC), 32'h01020304, 32'h04030201, '0);
    idle();
    chk("R6 not yet valid", out_valid == 1'b0, XW'(out_valid), 0);
    @(negedge clk);
    chk("R6 valid after 2nd edge", out_valid == 1'b1, XW'(out_valid), 1);
    drain();

    // R2 boundary, R3 wrap, R4/R5 decode variants
    send(mk(7'b1111110, 3'b000, OPC), 32'hFFFFFFFF, 32'h00000000, 32'h12345678);
    send(mk(7'b1111111, 3'b000, OPC), 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF);
    send(mk(7'b1111111, 3'b000, OPC), 32'h80808080, 32'h80808080, 32'hDEADBEEF);
    send(mk(7'b1111110, 3'b001, OPC), 32'hFFFFFFFF, 32'h0, 32'h5);
    send(mk(7'b1111110, 3'b000, 7'b1111011), 32'hFFFFFFFF, 32'h0, 32'h5);
    send(mk(7'b0111111, 3'b000, OPC), 32'hFFFFFFFF, 32'h0, 32'h5);
    send({7'b1111110, 5'd31, 5'd31, 3'b000, 5'd31, OPC}, 32'h7F80FF00, 32'h807F00FF, 32'h0);
    idle();
    drain();

    // R7: back-to-back stream with out_ready high
    stream_chk = 1'b1;
    for (int k = 0; k < 24; k++)
      send(mk(7'b1111111, 3'b000, OPC), XW'(k * 32'h01010101), XW'(32'h10203040 ^ k), XW'(k));
    stream_chk = 1'b0;
    idle();
    drain();

    // sweep under random back-pressure (R1, R3, R5, R8)
    bp_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a, b;
        logic [31:0] insn;
        a = 8'(i * 17); b = 8'(j * 17);
        case ((i + j) % 4)
          0: insn = mk(7'b1111110, 3'b000, OPC);
          1: insn = mk(7'b1111111, 3'b000, OPC);
          2: insn = mk(7'b1111111, 3'b000, OPC);
          default: insn = mk(7'(7'b1111100 + i % 3), 3'(j % 2), OPC);
        endcase
        send(insn, {a, b, ~a, 8'(a + j * 3)}, {b, a, 8'(b + 7), 8'(255 - b)},
             ((i + j) % 4 == 2) ? 32'hFFFFFF00 + XW'(i * j) : XW'(i * 256 + j));
      end
    end
    idle();
    drain();
    bp_en = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule